// File: doc/BRIEF.md
# Complete-Split Progress Tracker

This block follows the complete-split phase of one split isochronous IN transfer across the micro-frames of a frame. When a transfer descriptor is loaded, the block takes its enable mask, which has one bit per micro-frame slot. The bits that are set mark the slots in which a complete-split is scheduled. The block then records each complete-split that is allowed to run in a progress vector, at the bit position given by the current micro-frame index.

Complete-splits have to run in slot order. Before the block permits the complete-split for slot k, it checks that every enabled slot below k already has its progress bit set. If a hold-off has made an earlier slot go unserviced, the request is refused. The block then pulses a miss indication and sets a sticky error flag, but it does not halt. A later request that satisfies the ordering rule is still permitted, so errors are recorded per packet while the stream continues.

The sequence ends when a permitted complete-split either carries the last-data annotation or falls in the highest enabled slot. At that point the block pulses a done indication and drops its active status.

Top module: `csplit_progress`

## Requirements
- R1: After reset, the progress vector is zero, and the error flag, the active status and the permit, miss and done pulses are all 0.
- R2: A reload stores the enable mask, clears the progress vector and the error flag, and sets active to the OR of the mask bits. All of these are visible after the next clock edge.
- R3: A permitted complete-split request in slot k (k = micro-frame index, bit k of the progress vector) sets progress bit k. Permit is high in the cycle after the request.
- R4: A request in slot k is permitted only if every enabled bit below k is already set in the progress vector. Otherwise the miss pulse is raised, the error flag is set and the progress vector stays unchanged.
- R5: The error flag stays set until the next reload. After a miss, requests that satisfy R4 are still permitted.
- R6: A request is ignored, with no pulse and no change to the progress vector, when the enable bit for its slot is clear or when the block is not active.
- R7: A permitted request that carries last-data, or whose slot is the highest enabled slot, raises done in the next cycle and clears active.
- R8: Permit, miss and done are single-cycle pulses. They are 0 in any cycle that follows a cycle with no request.
- R9: If a reload and a request arrive in the same cycle, the reload wins and the request is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reload | input | 1 | Load a new descriptor enable mask and restart tracking |
| cmask_in | input | SLOTS | Enable mask of scheduled complete-split slots |
| uframe | input | log2(SLOTS) | Current micro-frame index |
| cs_req | input | 1 | Request to execute a complete-split in the current slot |
| last_data | input | 1 | The response to this request is the last data |
| cs_permit | output | 1 | Complete-split was allowed (pulse) |
| cs_miss | output | 1 | Request was refused because an earlier slot was skipped (pulse) |
| cs_done | output | 1 | Sequence has finished (pulse) |
| err_flag | output | 1 | Sticky error: a missed complete-split has been detected |
| active | output | 1 | A sequence is in progress |
| prog_mask | output | SLOTS | Progress vector of executed complete-splits |

## Verification
The assertions assume that reset is held low for at least one clock edge before any request. They also assume that the micro-frame index always names a valid slot, which holds for a power-of-two slot count. The random stimulus draws the index over the full index width. It reloads the descriptor every few dozen cycles with random masks, and these include the empty mask and masks with a single bit set. It also advances the slot both in order and with deliberate skips, so that requests land on enabled, disabled, already-serviced and out-of-order slots. A directed sequence skips one enabled slot and checks that the error flag rises exactly on the first out-of-order request and not before it.

// File: rtl/csplit_progress.sv
module csplit_progress #(
  parameter int SLOTS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reload,
  input  logic [SLOTS-1:0]           cmask_in,
  input  logic [$clog2(SLOTS)-1:0]   uframe,
  input  logic                       cs_req,
  input  logic                       last_data,
  output logic                       cs_permit,
  output logic                       cs_miss,
  output logic                       cs_done,
  output logic                       err_flag,
  output logic                       active,
  output logic [SLOTS-1:0]           prog_mask
);

  localparam logic [SLOTS-1:0] ONE = {{(SLOTS-1){1'b0}}, 1'b1};

  logic [SLOTS-1:0] cmask_q;
  logic [SLOTS-1:0] slot, below, need, above;
  logic             hit, order_ok, is_final, permit_now, miss_now, finish;

  assign slot       = ONE << uframe;
  assign below      = slot - ONE;
  assign need       = cmask_q & below;
  assign above      = cmask_q & ~(below | slot);
  assign order_ok   = (prog_mask & need) == need;
  assign is_final   = above == '0;
  assign hit        = cs_req && active && !reload && |(cmask_q & slot);
  assign permit_now = hit && order_ok;
  assign miss_now   = hit && !order_ok;
  assign finish     = permit_now && (last_data || is_final);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmask_q   <= '0;
      prog_mask <= '0;
      err_flag  <= 1'b0;
      active    <= 1'b0;
      cs_permit <= 1'b0;
      cs_miss   <= 1'b0;
      cs_done   <= 1'b0;
    end else begin
      cs_permit <= permit_now;
      cs_miss   <= miss_now;
      cs_done   <= finish;
      if (reload) begin
        cmask_q   <= cmask_in;
        prog_mask <= '0;
        err_flag  <= 1'b0;
        active    <= |cmask_in;
      end else begin
        if (permit_now) prog_mask <= prog_mask | slot;
        if (miss_now)   err_flag  <= 1'b1;
        if (finish)     active    <= 1'b0;
      end
    end
  end

  a_r4_permit_miss_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_permit && cs_miss));

  a_r2_reload_clears: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (prog_mask == '0) && !err_flag);

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !reload) |=> err_flag);

  a_r3_progress_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> (prog_mask & $past(prog_mask)) == $past(prog_mask));

  a_r7_done_drops_active: assert property (@(posedge clk) disable iff (!rst_n)
    cs_done |-> !active);

  a_r8_no_pulse_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_req |=> !cs_permit && !cs_miss && !cs_done);

  a_r4_miss_keeps_progress: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_miss && !$past(reload)) |-> $stable(prog_mask));

endmodule

// File: tb/csplit_progress_test.sv
`timescale 1ns/1ps
module csplit_progress_test;
  localparam int SLOTS = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reload = 1'b0;
  logic [SLOTS-1:0] cmask_in = '0;
  logic [IW-1:0] uframe = '0;
  logic cs_req = 1'b0;
  logic last_data = 1'b0;
  logic cs_permit, cs_miss, cs_done, err_flag, active;
  logic [SLOTS-1:0] prog_mask;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [SLOTS-1:0] m_cm, m_prog;
  logic m_err, m_act, e_permit, e_miss, e_done;

  csplit_progress #(.SLOTS(SLOTS)) uut (
    .clk(clk), .rst_n(rst_n), .reload(reload), .cmask_in(cmask_in),
    .uframe(uframe), .cs_req(cs_req), .last_data(last_data),
    .cs_permit(cs_permit), .cs_miss(cs_miss), .cs_done(cs_done),
    .err_flag(err_flag), .active(active), .prog_mask(prog_mask)
  );

  always #5 clk = ~clk;

  function automatic bit order_ok(logic [SLOTS-1:0] cm, logic [SLOTS-1:0] pg, int k);
    for (int i = 0; i < k; i++)
      if (cm[i] && !pg[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int top_slot(logic [SLOTS-1:0] cm);
    int t = -1;
    for (int i = 0; i < SLOTS; i++) if (cm[i]) t = i;
    return t;
  endfunction

  task automatic chk(string tag, logic [SLOTS-1:0] act, logic [SLOTS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 prog_mask", prog_mask, m_prog);
    chk("R3 permit", SLOTS'(cs_permit), SLOTS'(e_permit));
    chk("R4 miss", SLOTS'(cs_miss), SLOTS'(e_miss));
    chk("R5 err_flag", SLOTS'(err_flag), SLOTS'(m_err));
    chk("R7 done", SLOTS'(cs_done), SLOTS'(e_done));
    chk("R2 active", SLOTS'(active), SLOTS'(m_act));
  endtask

  task automatic step(bit rl, logic [SLOTS-1:0] cm, int uf, bit rq, bit ld);
    reload = rl; cmask_in = cm; uframe = IW'(uf); cs_req = rq; last_data = ld;
    e_permit = 1'b0; e_miss = 1'b0; e_done = 1'b0;
    if (rl) begin
      m_cm = cm; m_prog = '0; m_err = 1'b0; m_act = |cm;
    end else if (rq && m_act && m_cm[uf]) begin
      if (order_ok(m_cm, m_prog, uf)) begin
        e_permit = 1'b1;
        m_prog[uf] = 1'b1;
        if (ld || uf == top_slot(m_cm)) begin e_done = 1'b1; m_act = 1'b0; end
      end else begin
        e_miss = 1'b1; m_err = 1'b1;
      end
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    m_cm = '0; m_prog = '0; m_err = 1'b0; m_act = 1'b0;
    e_permit = 1'b0; e_miss = 1'b0; e_done = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    compare_all();
    rst_n = 1'b1;

    // R6: inactive block ignores requests
    step(0, '0, 2, 1, 0);
    // R2: reload with slots 2..5 enabled
    step(1, 8'b0011_1100, 0, 0, 0);
    // R6: disabled slot ignored
    step(0, '0, 1, 1, 0);
    // R3: first slot permitted
    step(0, '0, 2, 1, 0);
    // R8: pulses drop without request
    step(0, '0, 3, 0, 0);
    // R4: skip slot 3, error must rise exactly here
    chk("R4 err before skip", SLOTS'(err_flag), '0);
    step(0, '0, 4, 1, 0);
    // R5: processing continues, sticky error
    step(0, '0, 3, 1, 0);
    step(0, '0, 4, 1, 0);
    // R7: highest enabled slot ends the sequence
    step(0, '0, 5, 1, 0);
    step(0, '0, 5, 1, 0);
    // R9: reload beats a same-cycle request
    step(1, 8'b0000_0011, 0, 1, 0);
    // R7: last-data ends early
    step(0, '0, 0, 1, 1);
    // R2: empty mask leaves block inactive
    step(1, '0, 0, 0, 0);
    step(0, '0, 0, 1, 0);

    for (int n = 0; n < 3000; n++) begin
      bit rl = ($urandom % 24) == 0;
      logic [SLOTS-1:0] cm = SLOTS'($urandom);
      int uf = int'($urandom % SLOTS);
      bit rq = ($urandom % 4) != 0;
      bit ld = ($urandom % 10) == 0;
      if (($urandom % 5) == 0) cm = SLOTS'(1) << ($urandom % SLOTS);
      step(rl, cm, uf, rq, ld);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule